// File: doc/BRIEF.md
# Ring-Buffer DMA Address Generator

This block produces the word address that one DMA channel uses on its next source or destination access, and decides, cycle by cycle, whether another word may move. It is driven by static configuration inputs, a level-sensitive GO control and a word-accepted pulse from the bus side of the channel. It returns the current address, a transfer-allowed flag and a one-cycle completion pulse. Bus signalling and data storage are handled elsewhere.

In memory mode the address advances by one 32-bit word for each accepted word and wraps from a programmable upper bound back to a programmable lower bound, so a buffer in memory is walked as a ring. A programmable stop address throttles the walk: the channel pauses whenever its address reaches the stop point and resumes once software moves the stop point. In peripheral mode the address is held, which suits a device register or a FIFO port. A word counter ends the channel after a programmed number of words (one-shot), or restarts at zero and keeps going (repetitive). Each completed count produces a pulse.

Top module: `ring_dma_agen`

## Requirements
- R1: In memory mode each accepted word (word_ack high while xfer_ok is high) moves cur_addr up by WORD_BYTES (4) on the next clock edge, unless R2 applies.
- R2: In memory mode, an accepted word taken while cur_addr equals the upper bound (cfg_hi_addr with its low two bits cleared) sets cur_addr to the lower bound (cfg_lo_addr with its low two bits cleared).
- R3: In peripheral mode (cfg_mem_mode low) cur_addr does not change when words are accepted.
- R4: While cfg_go is low, xfer_ok is low and word_ack has no effect on cur_addr or done_pulse; the first clock edge with cfg_go high loads cur_addr from cfg_start_addr and clears the word counter.
- R5: In memory mode xfer_ok is low whenever cur_addr equals cfg_stop_addr with its low two bits cleared; in peripheral mode the stop address is ignored.
- R6: In one-shot mode (cfg_repeat low) exactly cfg_xfer_len words are accepted, after which xfer_ok stays low until cfg_go is cleared and set again.
- R7: In repetitive mode (cfg_repeat high) the word counter returns to zero after cfg_xfer_len words and transfers continue without software action.
- R8: done_pulse is high for one cycle, in the cycle after the word that brings the count to cfg_xfer_len is accepted.
- R9: Clearing cfg_go stops the channel on the next clock edge, and cur_addr keeps its value while cfg_go stays low.
- R10: The two low bits of cur_addr are always zero; the low two bits of cfg_start_addr are dropped when it is loaded.
- R11: With cfg_xfer_len equal to zero no word is ever allowed.
- R12: After reset cur_addr is zero and xfer_ok and done_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_go | input | 1 | Channel enable level; rising starts a run |
| cfg_mem_mode | input | 1 | 1 = memory (stepping) mode, 0 = peripheral (fixed) mode |
| cfg_repeat | input | 1 | 1 = repetitive, 0 = one-shot |
| cfg_start_addr | input | ADDR_W | Address loaded when a run starts |
| cfg_lo_addr | input | ADDR_W | Lower bound of the ring window |
| cfg_hi_addr | input | ADDR_W | Upper bound (last word) of the ring window |
| cfg_stop_addr | input | ADDR_W | Address at which memory-mode flow pauses |
| cfg_xfer_len | input | CNT_W | Words per pass |
| word_ack | input | 1 | One word was moved this cycle |
| cur_addr | output | ADDR_W | Address for the next word |
| xfer_ok | output | 1 | Another word may move this cycle |
| done_pulse | output | 1 | One-cycle pulse when a pass completes |

## Verification
The bound checker watches, on every cycle, that the address stays word aligned, steps by one word or wraps to the lower bound after each accepted memory-mode word, holds in peripheral mode and while GO is low, and that the allow flag is low whenever GO is clear, the length is zero, the stop address is reached in memory mode, or a one-shot pass has just finished. The exact word count of a pass, the cycle of the completion pulse, the restart of the counter in repetitive mode and the reload of the start address on a new GO can only be shown by the bench's scenarios, which count accepted words and pulses against hand-worked expectations.

// File: rtl/ring_agen_pkg.sv
`timescale 1ns/1ps
package ring_agen_pkg;

   typedef enum logic [1:0] {
      AG_IDLE = 2'd0,
      AG_RUN  = 2'd1,
      AG_HALT = 2'd2
   } ag_state_e;

   function automatic int unsigned agen_lsb(input int unsigned bytes);
      int unsigned n;
      n = 0;
      while ((1 << n) < bytes) n++;
      return n;
   endfunction

endpackage

// File: rtl/ring_agen_addr.sv
`timescale 1ns/1ps
module ring_agen_addr #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step_en,
   input  logic              mem_mode,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic [ADDR_W-1:0] stop_addr,
   output logic [ADDR_W-1:0] addr,
   output logic              at_stop
);
   import ring_agen_pkg::*;

   localparam int unsigned LSB = agen_lsb(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] start_al, lo_al, hi_al, stop_al;
   logic [ADDR_W-1:0] addr_q, addr_d;

   generate
      if ((1 << LSB) != WORD_BYTES) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (LSB == 0) begin : g_byte
         assign start_al = start_addr;
         assign lo_al    = lo_addr;
         assign hi_al    = hi_addr;
         assign stop_al  = stop_addr;
      end else begin : g_word
         assign start_al = {start_addr[ADDR_W-1:LSB], {LSB{1'b0}}};
         assign lo_al    = {lo_addr[ADDR_W-1:LSB],    {LSB{1'b0}}};
         assign hi_al    = {hi_addr[ADDR_W-1:LSB],    {LSB{1'b0}}};
         assign stop_al  = {stop_addr[ADDR_W-1:LSB],  {LSB{1'b0}}};
      end
   endgenerate

   always_comb begin
      addr_d = addr_q;
      if (load) begin
         addr_d = start_al;
      end else if (step_en && mem_mode) begin
         addr_d = (addr_q == hi_al) ? lo_al : addr_q + STEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_d;
   end

   assign addr    = addr_q;
   assign at_stop = (addr_q == stop_al);

endmodule

// File: rtl/ring_agen_count.sv
`timescale 1ns/1ps
module ring_agen_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   input  logic [CNT_W-1:0] len,
   output logic             last,
   output logic             len_nz
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + CNT_W'(1);
   assign last    = (cnt_inc == len);
   assign len_nz  = (len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= last ? '0 : cnt_inc;
      end
   end

endmodule

// File: rtl/ring_agen_ctrl.sv
`timescale 1ns/1ps
module ring_agen_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic repeat_en,
   input  logic mem_mode,
   input  logic at_stop,
   input  logic len_nz,
   input  logic last,
   input  logic word_ack,
   output logic start_load,
   output logic accept,
   output logic xfer_ok,
   output logic done_pulse
);
   import ring_agen_pkg::*;

   ag_state_e st_q, st_d;
   logic      done_q;

   assign xfer_ok    = (st_q == AG_RUN) && go && len_nz && !(mem_mode && at_stop);
   assign accept     = xfer_ok && word_ack;
   assign start_load = (st_q == AG_IDLE) && go;

   always_comb begin
      st_d = st_q;
      case (st_q)
         AG_IDLE: if (go) st_d = AG_RUN;
         AG_RUN: begin
            if (!go)                                 st_d = AG_IDLE;
            else if (accept && last && !repeat_en)   st_d = AG_HALT;
         end
         AG_HALT: if (!go) st_d = AG_IDLE;
         default: st_d = AG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= AG_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= accept && last;
      end
   end

   assign done_pulse = done_q;

endmodule

// File: rtl/ring_dma_agen.sv
`timescale 1ns/1ps
module ring_dma_agen #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_go,
   input  logic              cfg_mem_mode,
   input  logic              cfg_repeat,
   input  logic [ADDR_W-1:0] cfg_start_addr,
   input  logic [ADDR_W-1:0] cfg_lo_addr,
   input  logic [ADDR_W-1:0] cfg_hi_addr,
   input  logic [ADDR_W-1:0] cfg_stop_addr,
   input  logic [CNT_W-1:0]  cfg_xfer_len,
   input  logic              word_ack,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              xfer_ok,
   output logic              done_pulse
);
   logic start_load, accept, at_stop, last, len_nz;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too small");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   ring_agen_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (cfg_go),
      .repeat_en  (cfg_repeat),
      .mem_mode   (cfg_mem_mode),
      .at_stop    (at_stop),
      .len_nz     (len_nz),
      .last       (last),
      .word_ack   (word_ack),
      .start_load (start_load),
      .accept     (accept),
      .xfer_ok    (xfer_ok),
      .done_pulse (done_pulse)
   );

   ring_agen_count #(.CNT_W(CNT_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start_load),
      .inc    (accept),
      .len    (cfg_xfer_len),
      .last   (last),
      .len_nz (len_nz)
   );

   ring_agen_addr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start_load),
      .step_en    (accept),
      .mem_mode   (cfg_mem_mode),
      .start_addr (cfg_start_addr),
      .lo_addr    (cfg_lo_addr),
      .hi_addr    (cfg_hi_addr),
      .stop_addr  (cfg_stop_addr),
      .addr       (cur_addr),
      .at_stop    (at_stop)
   );

endmodule

// File: rtl/ring_dma_agen_chk.sv
`timescale 1ns/1ps
module ring_dma_agen_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned WORD_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_go,
   input logic              cfg_mem_mode,
   input logic              cfg_repeat,
   input logic [ADDR_W-1:0] cfg_lo_addr,
   input logic [ADDR_W-1:0] cfg_hi_addr,
   input logic [ADDR_W-1:0] cfg_stop_addr,
   input logic [CNT_W-1:0]  cfg_xfer_len,
   input logic              word_ack,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              xfer_ok,
   input logic              done_pulse
);
   import ring_agen_pkg::*;

   localparam int unsigned LSB = agen_lsb(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << LSB) - ADDR_W'(1));

   logic [ADDR_W-1:0] hi_m, lo_m, stop_m;
   assign hi_m   = cfg_hi_addr & MASK;
   assign lo_m   = cfg_lo_addr & MASK;
   assign stop_m = cfg_stop_addr & MASK;

   AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && word_ack && cfg_mem_mode && cur_addr != hi_m)
      |=> cur_addr == $past(cur_addr) + STEP); // R1

   AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && word_ack && cfg_mem_mode && cur_addr == hi_m)
      |=> cur_addr == $past(lo_m)); // R2

   AST_PERIPH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && word_ack && !cfg_mem_mode)
      |=> cur_addr == $past(cur_addr)); // R3

   AST_GO_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_go |-> !xfer_ok); // R4

   AST_STOP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mem_mode && cur_addr == stop_m) |-> !xfer_ok); // R5

   AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && !$past(cfg_repeat)) |-> !xfer_ok); // R6

   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_go |=> cur_addr == $past(cur_addr)); // R9

   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_addr & ~MASK) == '0); // R10

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_xfer_len == '0) |-> !xfer_ok); // R11

endmodule

bind ring_dma_agen ring_dma_agen_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_go        (cfg_go),
   .cfg_mem_mode  (cfg_mem_mode),
   .cfg_repeat    (cfg_repeat),
   .cfg_lo_addr   (cfg_lo_addr),
   .cfg_hi_addr   (cfg_hi_addr),
   .cfg_stop_addr (cfg_stop_addr),
   .cfg_xfer_len  (cfg_xfer_len),
   .word_ack      (word_ack),
   .cur_addr      (cur_addr),
   .xfer_ok       (xfer_ok),
   .done_pulse    (done_pulse)
);

// File: tb/tb_ring_dma_agen.sv
`timescale 1ns/1ps
module tb_ring_dma_agen;

   localparam int ADDR_W = 32;
   localparam int CNT_W  = 16;

   typedef struct packed {
      logic        mem;
      logic        rpt;
      logic [31:0] lo;
      logic [31:0] hi;
      logic [31:0] stop;
      logic [31:0] start;
      logic [15:0] len;
      int          offer;
      int          words;
      logic [31:0] addr;
      int          dones;
      logic        ok_end;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 32'h100, 32'h10C, 32'hFFC,  32'h100,  16'd3, 10, 3, 32'h10C,  1, 1'b0},
      '{1'b1, 1'b0, 32'h100, 32'h10C, 32'hFFC,  32'h108,  16'd5, 10, 5, 32'h10C,  1, 1'b0},
      '{1'b0, 1'b0, 32'h0,   32'h0,   32'h2000, 32'h2000, 16'd4, 10, 4, 32'h2000, 1, 1'b0},
      '{1'b1, 1'b1, 32'h40,  32'h4C,  32'hFFC,  32'h40,   16'd2,  7, 7, 32'h4C,   3, 1'b1},
      '{1'b1, 1'b0, 32'h200, 32'h21C, 32'h208,  32'h200,  16'd8,  8, 2, 32'h208,  0, 1'b0},
      '{1'b0, 1'b1, 32'h0,   32'h0,   32'hFFC,  32'h30,   16'd1,  3, 3, 32'h30,   3, 1'b1},
      '{1'b1, 1'b0, 32'h500, 32'h5FC, 32'hFFC,  32'h500,  16'd0,  5, 0, 32'h500,  0, 1'b0}
   };
   localparam string TAGS [NV] = '{
      "R1 R6 R8", "R2 R6", "R3 R5 R6", "R7 R8 R2", "R5", "R7 R3 R8", "R11"
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_go = 1'b0;
   logic              cfg_mem_mode = 1'b0;
   logic              cfg_repeat = 1'b0;
   logic [ADDR_W-1:0] cfg_start_addr = '0;
   logic [ADDR_W-1:0] cfg_lo_addr = '0;
   logic [ADDR_W-1:0] cfg_hi_addr = '0;
   logic [ADDR_W-1:0] cfg_stop_addr = '0;
   logic [CNT_W-1:0]  cfg_xfer_len = '0;
   logic              word_ack = 1'b0;
   logic [ADDR_W-1:0] cur_addr;
   logic              xfer_ok;
   logic              done_pulse;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   ring_dma_agen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(4)) dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Offer up to n words, one per cycle while allowed; count words and pulses.
   task automatic run_window(input int n, input int cycles, output int words, output int dones);
      int left;
      left = n; words = 0; dones = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (done_pulse) dones++;
         if (xfer_ok && left > 0) begin
            word_ack = 1'b1; left--; words++;
         end else begin
            word_ack = 1'b0;
         end
      end
      @(negedge clk);
      if (done_pulse) dones++;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      int w, d;
      repeat (3) @(negedge clk);
      chk("R12 reset addr", cur_addr, 32'h0);
      chk("R12 reset ok", {31'b0, xfer_ok}, 32'h0);
      chk("R12 reset done", {31'b0, done_pulse}, 32'h0);
      rst_n = 1'b1;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cfg_mem_mode   = VECS[i].mem;
         cfg_repeat     = VECS[i].rpt;
         cfg_lo_addr    = VECS[i].lo;
         cfg_hi_addr    = VECS[i].hi;
         cfg_stop_addr  = VECS[i].stop;
         cfg_start_addr = VECS[i].start;
         cfg_xfer_len   = VECS[i].len;
         cfg_go         = 1'b1;
         run_window(VECS[i].offer, 30, w, d);
         chk({TAGS[i], " words"}, 32'(w), 32'(VECS[i].words));
         chk({TAGS[i], " addr"}, cur_addr, VECS[i].addr);
         chk({TAGS[i], " dones"}, 32'(d), 32'(VECS[i].dones));
         chk({TAGS[i], " ok_end"}, {31'b0, xfer_ok}, {31'b0, VECS[i].ok_end});
         cfg_go = 1'b0;
         repeat (2) @(negedge clk);
      end

      // R4: with GO low, acks are ignored
      cfg_mem_mode = 1'b1; cfg_repeat = 1'b0;
      cfg_lo_addr = 32'h100; cfg_hi_addr = 32'h1FC; cfg_stop_addr = 32'hFFC;
      cfg_start_addr = 32'h103; cfg_xfer_len = 16'd8;
      @(negedge clk);
      begin
         logic [31:0] held;
         held = cur_addr;
         word_ack = 1'b1;
         d = 0;
         repeat (3) begin
            @(negedge clk);
            if (done_pulse) d++;
         end
         word_ack = 1'b0;
         chk("R4 no go addr held", cur_addr, held);
         chk("R4 no go ok low", {31'b0, xfer_ok}, 32'h0);
         chk("R4 no go no done", 32'(d), 32'h0);
      end

      // R10: start address low bits dropped
      cfg_go = 1'b1;
      @(negedge clk);
      chk("R10 aligned start", cur_addr, 32'h100);
      chk("R4 ok after go", {31'b0, xfer_ok}, 32'h1);
      word_ack = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 two steps", cur_addr, 32'h108);

      // R9: clear GO with ack still high
      cfg_go = 1'b0;
      @(negedge clk);
      chk("R9 ok low after clear", {31'b0, xfer_ok}, 32'h0);
      chk("R9 addr kept", cur_addr, 32'h108);
      @(negedge clk);
      chk("R9 addr still kept", cur_addr, 32'h108);
      word_ack = 1'b0;

      // R4: new GO reloads start and clears the counter
      cfg_start_addr = 32'h100; cfg_xfer_len = 16'd2;
      cfg_go = 1'b1;
      run_window(5, 10, w, d);
      chk("R4 restart words", 32'(w), 32'd2);
      chk("R4 restart dones", 32'(d), 32'd1);
      chk("R6 restart addr", cur_addr, 32'h108);

      // R6: one-shot stays stopped until GO toggles
      chk("R6 halted", {31'b0, xfer_ok}, 32'h0);
      cfg_go = 1'b0;
      @(negedge clk);
      cfg_go = 1'b1;
      @(negedge clk);
      chk("R6 rerun allowed", {31'b0, xfer_ok}, 32'h1);
      cfg_go = 1'b0;
      @(negedge clk);

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule